// File: doc/BRIEF.md
# Privileged Interrupt Arbiter

This block decides, every clock cycle, whether a hart with user, supervisor and machine privilege levels should take an interrupt, and if so which cause number to report. It starts from the interrupts that are both pending and individually enabled. It then applies a filter that depends on the current privilege level, the two global enable bits (machine and supervisor), and a delegation mask. Among the interrupts that pass the filter, the one with the lowest bit index wins.

The winning cause is placed in an output register. That register has a valid/ready handshake toward the trap-entry logic, which consumes it. A one-cycle take strobe marks every cycle in which a new cause is loaded. While a cause waits to be accepted, the register does not change, whatever the inputs do. When nothing is eligible and nothing is held, the cause output reads zero. The width of the machine word, XLEN, is a parameter.

Top module: `trap_irq_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, take_o and cause_valid_o are 0 and cause_o is all zeros.
- R2: An interrupt is a candidate only if its bit is set in both irq_pend_i and irq_en_i. A pending bit whose enable bit is clear is never taken.
- R3: A candidate whose irq_deleg_i bit is 0 is eligible when priv_i is below 3 (machine), or when priv_i is 3 and m_gie_i is 1. The reserved encoding 2 is compared as a number.
- R4: A candidate whose irq_deleg_i bit is 1 is eligible when priv_i is 0 (user), or when priv_i is 1 (supervisor) and s_gie_i is 1. In privilege 2 or 3 it is never eligible. Privilege encodings: user=0, supervisor=1, machine=3.
- R5: When several interrupts are eligible, the one with the lowest bit index is reported, even if a lower-indexed candidate was filtered out.
- R6: A reported cause has bit XLEN-1 set to 1, the winning index in bits $clog2(XLEN)-1:0, and every other bit 0.
- R7: The register stage loads a cause on the clock edge after the inputs that make it eligible. take_o is 1 for exactly the cycle that follows each load, and is 0 in a cycle where no load took place.
- R8: While cause_valid_o is 1 and cause_ready_i is 0, cause_o and cause_valid_o keep their values and take_o is 0, whatever the interrupt inputs do.
- R9: When no interrupt is eligible and the register is empty or being accepted, the register clears at the next edge: cause_valid_o=0, take_o=0, cause_o=0.
- R10: Index XLEN-1 can win and is reported as XLEN-1 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_pend_i | input | XLEN | Pending interrupt vector |
| irq_en_i | input | XLEN | Per-interrupt enable vector |
| irq_deleg_i | input | XLEN | Delegation mask: 1 means the interrupt is handled at supervisor level |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| cause_ready_i | input | 1 | Consumer accepts the held cause |
| take_o | output | 1 | One-cycle strobe for each newly loaded cause |
| cause_valid_o | output | 1 | A cause is held in the output register |
| cause_o | output | XLEN | Encoded cause: interrupt flag in the top bit, index in the low bits |

## Verification
A single interrupt source is swept across all four privilege encodings, both global enables and both delegation settings. This separates the machine-level rule from the supervisor-level rule, and shows how the reserved encoding is handled. Vectors with several bits set check the lowest-index choice: one has a low candidate that is filtered out by delegation, and one has only the top index set. A pending bit whose enable bit is clear shows the candidate mask at work. A run with ready held low while the inputs change shows that the held cause stays frozen and that take_o is a single pulse. Dropping all requests then shows the register clearing to zero.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  function automatic int idx_width(input int xlen);
    return $clog2(xlen);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_eligibility.sv
module irq_eligibility
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] en_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  output logic [XLEN-1:0] elig_o
);
  logic m_level_ok;
  logic s_level_ok;
  logic [XLEN-1:0] cand;

  always_comb begin
    m_level_ok = (priv_i < PRIV_MACH)  || ((priv_i == PRIV_MACH)  && m_gie_i);
    s_level_ok = (priv_i < PRIV_SUPER) || ((priv_i == PRIV_SUPER) && s_gie_i);
    cand       = pend_i & en_i;
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign elig_o[b] = cand[b] & (deleg_i[b] ? s_level_ok : m_level_ok);
  end
endmodule

// File: rtl/irq_low_index.sv
module irq_low_index #(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             any_o,
  output logic [IDXW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDXW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/irq_cause_hold.sv
module irq_cause_hold #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_req_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic            ready_i,
  output logic            take_o,
  output logic            valid_o,
  output logic [XLEN-1:0] cause_o
);
  logic            valid_q, valid_d;
  logic            take_q, take_d;
  logic [XLEN-1:0] cause_q, cause_d;
  logic            slot_free;
  logic            cause_en;

  always_comb begin
    slot_free = !valid_q || ready_i;
    cause_en  = slot_free;
    valid_d   = valid_q;
    take_d    = 1'b0;
    cause_d   = cause_q;
    if (slot_free) begin
      valid_d = load_req_i;
      take_d  = load_req_i;
      cause_d = load_req_i ? cause_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      take_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      take_q <= take_d;
      if (cause_en) begin
        valid_q <= valid_d;
        cause_q <= cause_d;
      end
    end
  end

  assign take_o  = take_q;
  assign valid_o = valid_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] irq_pend_i,
  input  logic [XLEN-1:0] irq_en_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic            cause_ready_i,
  output logic            take_o,
  output logic            cause_valid_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int IDXW = $clog2(XLEN);
  localparam int PADW = XLEN - 1 - IDXW;

  logic            rst_sync_n;
  logic [XLEN-1:0] elig;
  logic            any_elig;
  logic [IDXW-1:0] win_idx;
  logic [XLEN-1:0] cause_next;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  irq_eligibility #(.XLEN(XLEN)) u_elig (
    .pend_i  (irq_pend_i),
    .en_i    (irq_en_i),
    .deleg_i (irq_deleg_i),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .elig_o  (elig)
  );

  irq_low_index #(.WIDTH(XLEN)) u_pick (
    .vec_i (elig),
    .any_o (any_elig),
    .idx_o (win_idx)
  );

  assign cause_next = {1'b1, {PADW{1'b0}}, win_idx};

  irq_cause_hold #(.XLEN(XLEN)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_req_i (any_elig),
    .cause_i    (cause_next),
    .ready_i    (cause_ready_i),
    .take_o     (take_o),
    .valid_o    (cause_valid_o),
    .cause_o    (cause_o)
  );
endmodule

// File: rtl/irq_sel_checker.sv
module irq_sel_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] irq_pend_i,
  input logic [XLEN-1:0] irq_en_i,
  input logic [XLEN-1:0] irq_deleg_i,
  input logic [1:0]      priv_i,
  input logic            cause_ready_i,
  input logic            take_o,
  input logic            cause_valid_o,
  input logic [XLEN-1:0] cause_o
);
  localparam int IDXW = $clog2(XLEN);

  // R7: a take pulse always comes with a held cause
  a_r7_take_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_valid_o);

  // R8: a stalled cause is frozen and raises no new take
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid_o && !cause_ready_i) |=> (cause_valid_o && $stable(cause_o) && !take_o));

  // R6: a held cause carries the interrupt flag and zero padding
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IDXW] == '0)));

  // R9: an empty register reads zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_valid_o |-> (cause_o == '0 && !take_o));

  // R2: no candidates means no load
  a_r2_no_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    (((irq_pend_i & irq_en_i) == '0) && (!cause_valid_o || cause_ready_i)) |=> !take_o);

  // R4: in machine mode only non-delegated candidates can be taken
  a_r4_mach_no_deleg: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_i == 2'd3) && ((irq_pend_i & irq_en_i & ~irq_deleg_i) == '0)
     && (!cause_valid_o || cause_ready_i)) |=> !take_o);
endmodule

bind trap_irq_arbiter irq_sel_checker #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_pend_i    (irq_pend_i),
  .irq_en_i      (irq_en_i),
  .irq_deleg_i   (irq_deleg_i),
  .priv_i        (priv_i),
  .cause_ready_i (cause_ready_i),
  .take_o        (take_o),
  .cause_valid_o (cause_valid_o),
  .cause_o       (cause_o)
);

// File: tb/sim_trap_irq_arbiter.sv
`timescale 1ns/1ps
module sim_trap_irq_arbiter;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]      priv = 2'd0;
  logic            mgie = 1'b0, sgie = 1'b0, rdy = 1'b1;
  logic            take, valid;
  logic [XLEN-1:0] cause;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_irq_arbiter #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pend_i(pend), .irq_en_i(en),
    .irq_deleg_i(deleg), .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie),
    .cause_ready_i(rdy), .take_o(take), .cause_valid_o(valid), .cause_o(cause)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] p, e, d,
                                             input logic [1:0] pr, input logic m, s);
    logic [XLEN-1:0] c = p & e;
    bit mok = (pr != 2'd3) || m;
    bit sok = (pr == 2'd0) || (pr == 2'd1 && s);
    for (int i = 0; i < XLEN; i++)
      if (c[i] && (d[i] ? sok : mok)) return {1'b1, {(XLEN-6){1'b0}}, 5'(i)};
    return '0;
  endfunction

  task automatic clear_all();
    pend = '0; rdy = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk(take == 0 && valid == 0, "R1 reset flags", {take, valid}, 0);
    chk(cause == '0, "R1 reset cause", cause, 0);
  endtask

  task automatic t_candidate();
    priv = 2'd0; deleg = '0; en = '0; pend = 32'h20;
    tick();
    chk(take == 0 && cause == '0, "R2 pending but disabled", cause, 0);
    en = 32'h20;
    tick();
    chk(take == 1 && cause == 32'h8000_0005, "R2 enabled candidate", cause, 32'h8000_0005);
    clear_all();
  endtask

  task automatic t_priv_matrix();
    en = '1;
    for (int pr = 0; pr < 4; pr++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
          for (int dl = 0; dl < 2; dl++) begin
            logic [XLEN-1:0] exp;
            priv = 2'(pr); mgie = m[0]; sgie = s[0];
            deleg = dl[0] ? '1 : '0; pend = 32'h8;
            exp = model(pend, en, deleg, priv, mgie, sgie);
            tick();
            if (dl[0]) chk(cause == exp && take == (exp != 0), "R4 delegated rule", cause, exp);
            else       chk(cause == exp && take == (exp != 0), "R3 machine rule", cause, exp);
            clear_all();
          end
  endtask

  task automatic t_lowest();
    en = '1; deleg = '0; priv = 2'd0;
    pend = 32'hF0F0_0100;
    tick();
    chk(cause == 32'h8000_0008, "R5 lowest of many", cause, 32'h8000_0008);
    chk(cause[30:5] == '0 && cause[31], "R6 format", cause, 32'h8000_0008);
    pend = 32'h84; deleg = 32'h4; priv = 2'd1; mgie = 0; sgie = 0;
    tick();
    chk(cause == 32'h8000_0007, "R5 filtered low bit skipped", cause, 32'h8000_0007);
    pend = 32'h8000_0000; deleg = '0; priv = 2'd0;
    tick();
    chk(cause == 32'h8000_001F, "R10 top index", cause, 32'h8000_001F);
    clear_all();
  endtask

  task automatic t_hold();
    en = '1; deleg = '0; priv = 2'd0; rdy = 0;
    pend = 32'h4;
    tick();
    chk(take == 1 && valid == 1 && cause == 32'h8000_0002, "R7 load pulse", cause, 32'h8000_0002);
    pend = 32'h2;
    tick();
    chk(take == 0, "R7 single cycle pulse", take, 0);
    chk(valid == 1 && cause == 32'h8000_0002, "R8 held while stalled", cause, 32'h8000_0002);
    pend = '0;
    tick();
    chk(valid == 1 && cause == 32'h8000_0002, "R8 held with no request", cause, 32'h8000_0002);
    pend = 32'h2; rdy = 1;
    tick();
    chk(take == 1 && cause == 32'h8000_0001, "R7 reload on accept", cause, 32'h8000_0001);
  endtask

  task automatic t_idle();
    pend = '0; rdy = 1;
    tick();
    chk(valid == 0 && take == 0 && cause == '0, "R9 cleared when idle", cause, 0);
    tick();
    chk(valid == 0 && cause == '0, "R9 stays clear", cause, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_candidate();
    t_priv_matrix();
    t_lowest();
    t_hold();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule